// File: doc/BRIEF.md
# Filtered Quadrature and Count-Input Decoder

This block sits in front of a position or event counter. It takes two raw, asynchronous count inputs and reduces them to single-cycle up and down strobes, plus a direction flag. The inputs can be read as a quadrature pair at one, two or four counts per input cycle. They can also be read as two plain clocks, or as a clock with a level that selects the direction.

In quadrature mode each input must hold a new level for a programmable number of system clocks before the decoder accepts it. This rejects short glitches. A global enable and an optional active-low gate pin can both stop counting. Software can also request one increment or one decrement. When an input count and a software step land in the same cycle, no count is lost: opposite requests cancel, and a surplus is carried into the following cycles.

Top module: `quad_count_decoder`

## Requirements
- R1: After reset both strobes are low and the direction flag reads 1.
- R2: With quad_mode=2'b11 (x4), every accepted edge of either input counts. The forward sequence of (in_a,in_b) is 00,10,11,01,00 and gives four up strobes per cycle. The reverse sequence gives four down strobes.
- R3: With quad_mode=2'b10 (x2), only edges of in_a count, giving two strobes per quadrature cycle. The direction follows the same rule as R2.
- R4: With quad_mode=2'b01 (x1), a count occurs only on a rising edge of in_a. It is up when in_b is 0 and down when in_b is 1.
- R5: In any quadrature mode, an input level held for fewer than FILT_LEN system clocks after synchronisation is ignored and produces no strobe.
- R6: With quad_mode=2'b00 and dir_mode=0, a rising edge of in_a gives one up count and a rising edge of in_b gives one down count. Rising edges on both in the same cycle produce no net count.
- R7: With quad_mode=2'b00 and dir_mode=1, each rising edge of in_a counts once: up when in_b is 0, down when in_b is 1.
- R8: The direction flag reads 1 whenever quad_mode is 00. Otherwise it shows the direction of the last enabled quadrature count, and it does not change while inputs_en is low.
- R9: While inputs_en is 0, neither input edges nor software steps create counts. Only an already pending backlog of at most three counts drains.
- R10: When gate_use is 1, gate_n=1 blocks counting exactly as R9 does, and gate_n=0 allows it. When gate_use is 0, gate_n has no effect.
- R11: A one-cycle pulse on step_up or step_dn yields exactly one up or down strobe. Both asserted together yield none.
- R12: Up and down strobes are never high together. When an input count and a step coincide, the strobes still sum to the net number of requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_a | input | 1 | Raw count input A (asynchronous) |
| in_b | input | 1 | Raw count input B (asynchronous) |
| quad_mode | input | 2 | 00 off, 01 x1, 10 x2, 11 x4 |
| dir_mode | input | 1 | Non-quadrature scheme: 0 up/down clocks, 1 clock plus direction |
| inputs_en | input | 1 | Global count enable |
| gate_use | input | 1 | 1 makes gate_n act as an enable gate |
| gate_n | input | 1 | Active-low external enable gate |
| step_up | input | 1 | Software single increment request |
| step_dn | input | 1 | Software single decrement request |
| up_pulse | output | 1 | One-cycle up-count strobe |
| dn_pulse | output | 1 | One-cycle down-count strobe |
| dir_up | output | 1 | Direction flag, 1 means counting up |

## Verification
The two functions that can coincide are a decoded input count and a software step. Both feed the single pair of strobes. The bench raises in_a once and then sweeps a step request, of the opposite or the same direction, across every cycle offset around the moment the input count emerges, so that one offset lands on the same cycle. For each offset it judges the run by its totals. Opposite requests must leave equal up and down totals, with no more than one of each, and at least one offset must show full cancellation. Same-direction requests must always give exactly two up strobes.

// File: rtl/quad_count_decoder.sv
module quad_count_decoder #(
  parameter int FILT_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_a,
  input  logic       in_b,
  input  logic [1:0] quad_mode,
  input  logic       dir_mode,
  input  logic       inputs_en,
  input  logic       gate_use,
  input  logic       gate_n,
  input  logic       step_up,
  input  logic       step_dn,
  output logic       up_pulse,
  output logic       dn_pulse,
  output logic       dir_up
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] CLAST = CW'(FILT_LEN - 1);

  logic [1:0] sync1, sync2, filt, prev;
  logic       quad_on, en, inc, dec, dir_q;
  logic signed [3:0] pend, acc, inp, stp, npend;

  assign quad_on = quad_mode != 2'b00;
  assign en      = inputs_en & ~(gate_use & gate_n);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= {in_b, in_a};
      sync2 <= sync1;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_filt
    logic [CW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        filt[g] <= 1'b0;
        cnt     <= '0;
      end else if (!quad_on || sync2[g] == filt[g]) begin
        filt[g] <= sync2[g];
        cnt     <= '0;
      end else if (cnt == CLAST) begin
        filt[g] <= sync2[g];
        cnt     <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= '0;
    else        prev <= filt;
  end

  logic a_edge, b_edge, a_rise, b_rise;
  assign a_edge = filt[0] ^ prev[0];
  assign b_edge = filt[1] ^ prev[1];
  assign a_rise = filt[0] & ~prev[0];
  assign b_rise = filt[1] & ~prev[1];

  always_comb begin
    inc = 1'b0;
    dec = 1'b0;
    case (quad_mode)
      2'b11: begin
        if (a_edge && !b_edge) begin
          inc = filt[0] ^ filt[1];
          dec = ~(filt[0] ^ filt[1]);
        end else if (b_edge && !a_edge) begin
          inc = ~(filt[0] ^ filt[1]);
          dec = filt[0] ^ filt[1];
        end
      end
      2'b10: if (a_edge) begin
        inc = filt[0] ^ filt[1];
        dec = ~(filt[0] ^ filt[1]);
      end
      2'b01: if (a_rise) begin
        inc = ~filt[1];
        dec = filt[1];
      end
      default: begin
        if (dir_mode) begin
          inc = a_rise & ~filt[1];
          dec = a_rise & filt[1];
        end else begin
          inc = a_rise;
          dec = b_rise;
        end
      end
    endcase
  end

  assign inp = en ? (4'(inc) - 4'(dec)) : 4'sd0;
  assign stp = en ? (4'(step_up) - 4'(step_dn)) : 4'sd0;
  assign acc = inp + stp + pend;

  always_comb begin
    npend = acc;
    if (acc > 0)      npend = acc - 4'sd1;
    else if (acc < 0) npend = acc + 4'sd1;
    if (npend > 4'sd3)       npend = 4'sd3;
    else if (npend < -4'sd3) npend = -4'sd3;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= '0;
      up_pulse <= 1'b0;
      dn_pulse <= 1'b0;
      dir_q    <= 1'b1;
    end else begin
      pend     <= npend;
      up_pulse <= acc > 0;
      dn_pulse <= acc < 0;
      if (quad_on && en && (inc ^ dec)) dir_q <= inc;
    end
  end

  assign dir_up = ~quad_on | dir_q;
endmodule

module quad_count_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] quad_mode,
  input logic       inputs_en,
  input logic       gate_use,
  input logic       gate_n,
  input logic       up_pulse,
  input logic       dn_pulse,
  input logic       dir_up
);
  a_r12_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_pulse && dn_pulse));

  a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!inputs_en, 1) && $past(!inputs_en, 2) && $past(!inputs_en, 3) && $past(!inputs_en, 4))
    |-> (!up_pulse && !dn_pulse));

  a_r10_gate_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gate_use && gate_n, 1) && $past(gate_use && gate_n, 2) &&
     $past(gate_use && gate_n, 3) && $past(gate_use && gate_n, 4))
    |-> (!up_pulse && !dn_pulse));

  a_r8_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!inputs_en) && $past(quad_mode) == quad_mode && $past(rst_n)) |-> $stable(dir_up));
endmodule

bind quad_count_decoder quad_count_decoder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .quad_mode(quad_mode), .inputs_en(inputs_en),
  .gate_use(gate_use), .gate_n(gate_n), .up_pulse(up_pulse),
  .dn_pulse(dn_pulse), .dir_up(dir_up));

// File: tb/quad_count_decoder_tb.sv
module quad_count_decoder_tb_top;
  logic clk = 0, rst_n = 0;
  logic in_a = 0, in_b = 0, dir_mode = 0, inputs_en = 1, gate_use = 0, gate_n = 0;
  logic step_up = 0, step_dn = 0;
  logic [1:0] quad_mode = 2'b00;
  logic up_pulse, dn_pulse, dir_up;
  int ups = 0, dns = 0, n_chk = 0, n_bad = 0, cycles = 0;

  always #4 clk = ~clk;

  quad_count_decoder #(.FILT_LEN(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .quad_mode(quad_mode),
    .dir_mode(dir_mode), .inputs_en(inputs_en), .gate_use(gate_use), .gate_n(gate_n),
    .step_up(step_up), .step_dn(step_dn), .up_pulse(up_pulse), .dn_pulse(dn_pulse),
    .dir_up(dir_up));

  always @(negedge clk) if (rst_n) begin
    ups += int'(up_pulse);
    dns += int'(dn_pulse);
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wc(int n); repeat (n) @(negedge clk); endtask
  task automatic setab(logic a, logic b); @(negedge clk); in_a = a; in_b = b; wc(10); endtask
  task automatic clr; wc(6); ups = 0; dns = 0; endtask
  task automatic fwd(int n);
    for (int i = 0; i < n; i++) begin setab(1,0); setab(1,1); setab(0,1); setab(0,0); end
  endtask
  task automatic rev(int n);
    for (int i = 0; i < n; i++) begin setab(0,1); setab(1,1); setab(1,0); setab(0,0); end
  endtask
  task automatic pulse_a(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); in_a = 1; wc(6); in_a = 0; wc(6); end
  endtask
  task automatic pulse_b(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); in_b = 1; wc(6); in_b = 0; wc(6); end
  endtask
  task automatic step(logic u, logic d);
    @(negedge clk); step_up = u; step_dn = d; @(negedge clk); step_up = 0; step_dn = 0; wc(4);
  endtask

  initial begin
    while (cycles < 150000 && n_chk < 1000000) begin @(posedge clk); cycles++; end
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=%0d expected=done", cycles);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    wc(3); rst_n = 1; wc(1);
    chk("R1 up", int'(up_pulse), 0); chk("R1 dn", int'(dn_pulse), 0); chk("R1 dir", int'(dir_up), 1);

    for (int m = 1; m <= 3; m++) begin
      quad_mode = 2'(m); clr;
      fwd(3); wc(4);
      chk(m == 3 ? "R2 x4 fwd up" : m == 2 ? "R3 x2 fwd up" : "R4 x1 fwd up", ups, 3 * (m == 3 ? 4 : m == 2 ? 2 : 1));
      chk("R2/R3/R4 fwd dn", dns, 0);
      chk("R8 dir fwd", int'(dir_up), 1);
      clr; rev(2); wc(4);
      chk(m == 3 ? "R2 x4 rev dn" : m == 2 ? "R3 x2 rev dn" : "R4 x1 rev dn", dns, 2 * (m == 3 ? 4 : m == 2 ? 2 : 1));
      chk("R2/R3/R4 rev up", ups, 0);
      chk("R8 dir rev", int'(dir_up), 0);
    end

    quad_mode = 2'b11; clr;
    for (int w = 1; w <= 3; w++) begin
      @(negedge clk); in_a = 1; wc(w); in_a = 0; wc(12);
    end
    chk("R5 glitch ignored", ups + dns, 0);
    @(negedge clk); in_a = 1; wc(5); in_a = 0; wc(12);
    chk("R5 long pulse accepted", ups + dns, 2);

    inputs_en = 0; clr; fwd(1); wc(4);
    chk("R9 quad disabled", ups + dns, 0);
    chk("R8 dir held while disabled", int'(dir_up), 0);
    inputs_en = 1;

    quad_mode = 2'b00; dir_mode = 0; wc(2);
    chk("R8 dir forced", int'(dir_up), 1);
    clr; pulse_a(5); pulse_b(3); wc(4);
    chk("R6 up clocks", ups, 5); chk("R6 dn clocks", dns, 3);
    clr; @(negedge clk); in_a = 1; in_b = 1; wc(6); in_a = 0; in_b = 0; wc(8);
    chk("R6 both rise cancels", ups + dns, 0);

    dir_mode = 1; clr; in_b = 0; pulse_a(4); wc(4);
    chk("R7 dir0 up", ups, 4); chk("R7 dir0 dn", dns, 0);
    clr; @(negedge clk); in_b = 1; wc(3); pulse_a(2); in_b = 0; wc(4);
    chk("R7 dir1 dn", dns, 2); chk("R7 dir1 up", ups, 0);
    dir_mode = 0;

    inputs_en = 0; clr; pulse_a(2); step(1,0); step(0,1); wc(4);
    chk("R9 disabled", ups + dns, 0);
    inputs_en = 1;

    gate_use = 1; gate_n = 1; clr; pulse_a(2); step(1,0); wc(4);
    chk("R10 gate blocks", ups + dns, 0);
    gate_n = 0; clr; pulse_a(2); wc(4);
    chk("R10 gate open", ups, 2);
    gate_use = 0; gate_n = 1; clr; pulse_a(3); wc(4);
    chk("R10 gate unused", ups, 3);
    gate_n = 0;

    clr; step(1,0); step(1,0); step(1,0); step(0,1); step(0,1);
    chk("R11 step up", ups, 3); chk("R11 step dn", dns, 2);
    clr; step(1,1);
    chk("R11 both cancel", ups + dns, 0);

    begin
      int hits = 0;
      for (int off = 0; off < 9; off++) begin
        clr;
        @(negedge clk); in_a = 1;
        wc(off); step_dn = 1; @(negedge clk); step_dn = 0;
        wc(8); in_a = 0; wc(6);
        chk("R12 opposite balance", ups - dns, 0);
        chk("R12 opposite at most one", (ups <= 1) ? 1 : 0, 1);
        if (ups == 0) hits++;
      end
      chk("R12 collision reached", (hits > 0) ? 1 : 0, 1);
      for (int off = 0; off < 9; off++) begin
        clr;
        @(negedge clk); in_a = 1;
        wc(off); step_up = 1; @(negedge clk); step_up = 0;
        wc(8); in_a = 0; wc(6);
        chk("R12 same-direction no loss", ups, 2);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule